// File: doc/BRIEF.md
# Timed Erase Block-Select Collector

This block gathers the set of array blocks that one block-erase operation will clear. The command decoder pulses an arm input when it accepts the confirm write of a block-erase sequence. The block select held in the top address bits during that write becomes the first chosen block. The collector then stays in a load phase. Every further write strobe that begins in this phase adds the block named by its address bits to an eight-bit selection mask. Any number of blocks from one to all eight can be chosen, and naming a block twice is harmless.

The load phase has no closing command. It ends when the strobe has been inactive for a programmable number of clock cycles. The count restarts every time a strobe ends. When the window lapses, the block raises a one-cycle start pulse for the erase engine, with the final mask. It then reports busy and holds the mask steady until the engine signals completion. At that point the mask is cleared and the block goes back to idle. An abort during loading discards the selection and gives no start pulse.

Top module: `blk_erase_collector`

## Requirements
- R1: After reset, selMask is 0 and both busyOut and startOut are 0.
- R2: An armIn pulse while idle enters the load phase and sets mask bit addrIn[16:14]. With the default 17-bit address, bit k of selMask stands for block k.
- R3: During loading, every cycle in which wrStb rises from 0 to 1 sets the mask bit named by addrIn[16:14] in that cycle. Bits accumulate, so any non-empty subset of the eight blocks can be gathered.
- R4: Loading a block that is already selected leaves its bit set, leaves the other bits unchanged, and restarts the window.
- R5: Each clock edge at which wrStb is 0 during loading counts toward the window. The count restarts on arming and at every edge where wrStb is 1. startOut is 1 in the cycle that follows the WINDOW_CYC-th consecutive counted edge.
- R6: startOut lasts exactly one cycle. While it is 1, busyOut is 1 and selMask holds the complete non-empty selection.
- R7: While busyOut is 1, selMask holds its value and strobes have no effect, until doneIn arrives.
- R8: doneIn while busy clears selMask and busyOut at the next edge and returns the block to idle.
- R9: abortIn during loading clears selMask and returns the block to idle. No start pulse follows.
- R10: While idle, wrStb and abortIn have no effect: selMask stays 0 and no start pulse occurs.
- R11: While wrStb is held at 1 during loading, the window does not expire, however long the strobe lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armIn | input | 1 | Pulse from the command decoder on the accepted confirm write |
| wrStb | input | 1 | Write strobe level, 1 while the write is active |
| addrIn | input | 17 | Address; the top three bits select the block |
| abortIn | input | 1 | Abandon the load phase |
| doneIn | input | 1 | Erase engine completion |
| selMask | output | 8 | Selected-block mask |
| startOut | output | 1 | One-cycle erase start pulse |
| busyOut | output | 1 | Erase in progress |

## Verification
The in-line assertions check properties that hold on every cycle. The start pulse is one cycle wide, it never comes with an empty mask, and busy is set while it is high. The mask only gains bits unless a clear is commanded. It holds steady while busy. A completion or an abort always ends with an empty mask in idle. The timer never runs past its limit. The exact cycle on which the window lapses, the match between the collected mask and the blocks that were strobed, and the reset of the window by repeated or held strobes can only be shown by the bench's timed sequences.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } ebcState_t;

  typedef struct packed {
    logic clearAll;
    logic setSel;
    logic timerClr;
    logic timerInc;
  } ebcCtrl_t;
endpackage

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int NUM_BLK    = 8,
  parameter int WINDOW_CYC = 1500000,
  localparam int SEL_W     = $clog2(NUM_BLK),
  localparam int CNT_W     = $clog2(WINDOW_CYC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ebcCtrl_t           ctrl,
  input  logic               wrStb,
  input  logic [SEL_W-1:0]   blkSel,
  output logic [NUM_BLK-1:0] flags,
  output logic               stbLead,
  output logic               windowOut
);
  logic             stbQ;
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= 1'b0;
    else       stbQ <= wrStb;
  end

  assign stbLead = wrStb & ~stbQ;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            flags[i] <= 1'b0;
      else if (ctrl.clearAll)                               flags[i] <= 1'b0;
      else if (ctrl.setSel && blkSel == SEL_W'(i))          flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idleCnt <= '0;
    else if (ctrl.timerClr) idleCnt <= '0;
    else if (ctrl.timerInc) idleCnt <= idleCnt + 1'b1;
  end

  assign windowOut = (idleCnt == CNT_W'(WINDOW_CYC - 1));

  // R5: the idle counter stops at the window limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_W'(WINDOW_CYC - 1));

  // R3: without a clear, no selected bit is ever dropped
  p_flags_grow_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clearAll |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/ebc_control.sv
module ebc_control
  import ebc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      armIn,
  input  logic      abortIn,
  input  logic      doneIn,
  input  logic      wrStb,
  input  logic      stbLead,
  input  logic      windowOut,
  output ebcCtrl_t  ctrl,
  output logic      startOut,
  output logic      busyOut
);
  ebcState_t state, stateNext;
  logic      fire;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    fire      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (armIn) begin
          ctrl.setSel   = 1'b1;
          ctrl.timerClr = 1'b1;
          stateNext     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (abortIn) begin
          ctrl.clearAll = 1'b1;
          ctrl.timerClr = 1'b1;
          stateNext     = ST_IDLE;
        end else if (wrStb) begin
          ctrl.setSel   = stbLead;
          ctrl.timerClr = 1'b1;
        end else if (windowOut) begin
          ctrl.timerClr = 1'b1;
          fire          = 1'b1;
          stateNext     = ST_RUN;
        end else begin
          ctrl.timerInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (doneIn) begin
          ctrl.clearAll = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      startOut <= 1'b0;
    end else begin
      state    <= stateNext;
      startOut <= fire;
    end
  end

  assign busyOut = (state == ST_RUN);

  // R6: start is a single-cycle pulse
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    startOut |=> !startOut);

  // R6: busy is already set while start is high
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    startOut |-> busyOut);

  // R9: abort in loading returns to idle with no start
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && abortIn) |=> (state == ST_IDLE && !startOut));
endmodule

// File: rtl/blk_erase_collector.sv
module blk_erase_collector
  import ebc_pkg::*;
#(
  parameter int NUM_BLK    = 8,
  parameter int ADDR_W     = 17,
  parameter int WINDOW_CYC = 1500000,
  localparam int SEL_W     = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armIn,
  input  logic               wrStb,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               abortIn,
  input  logic               doneIn,
  output logic [NUM_BLK-1:0] selMask,
  output logic               startOut,
  output logic               busyOut
);
  ebcCtrl_t ctrl;
  logic     stbLead;
  logic     windowOut;

  ebc_datapath #(.NUM_BLK(NUM_BLK), .WINDOW_CYC(WINDOW_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrStb    (wrStb),
    .blkSel   (addrIn[ADDR_W-1 -: SEL_W]),
    .flags    (selMask),
    .stbLead  (stbLead),
    .windowOut(windowOut)
  );

  ebc_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .armIn    (armIn),
    .abortIn  (abortIn),
    .doneIn   (doneIn),
    .wrStb    (wrStb),
    .stbLead  (stbLead),
    .windowOut(windowOut),
    .ctrl     (ctrl),
    .startOut (startOut),
    .busyOut  (busyOut)
  );

  // R6: a start pulse never carries an empty mask
  p_start_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    startOut |-> (selMask != '0));

  // R7: mask frozen while busy and not yet done
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !doneIn) |=> $stable(selMask));

  // R8: completion clears mask and busy
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && doneIn) |=> (selMask == '0 && !busyOut));
endmodule

// File: tb/blk_erase_collector_test.sv
module blk_erase_collector_test;
  localparam int T = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armIn = 1'b0, wrStb = 1'b0, abortIn = 1'b0, doneIn = 1'b0;
  logic [16:0] addrIn = '0;
  logic [7:0]  selMask;
  logic        startOut, busyOut;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  blk_erase_collector #(.WINDOW_CYC(T)) uut (
    .clk(clk), .rstN(rstN), .armIn(armIn), .wrStb(wrStb), .addrIn(addrIn),
    .abortIn(abortIn), .doneIn(doneIn), .selMask(selMask),
    .startOut(startOut), .busyOut(busyOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] blkAddr(input int b, input int salt);
    return {3'(b), 14'(salt * 977 + 5)};
  endfunction

  task automatic arm(input int b);
    addrIn = blkAddr(b, b + 3);
    armIn  = 1'b1;
    @(negedge clk);
    armIn  = 1'b0;
  endtask

  task automatic strobe(input int b, input int width);
    addrIn = blkAddr(b, width);
    wrStb  = 1'b1;
    repeat (width) @(negedge clk);
    wrStb  = 1'b0;
    addrIn = '1;
  endtask

  task automatic gap(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!startOut, req, startOut, 0);
    end
  endtask

  task automatic expectStart(input logic [7:0] expMask, input string req);
    int n = 0;
    bit seen = 0;
    for (int i = 0; i < T + 3 && !seen; i++) begin
      @(negedge clk);
      n++;
      if (startOut) seen = 1;
    end
    check(seen && n == T, {req, " start cycle"}, n, T);
    check(selMask == expMask && busyOut, {req, " mask"}, selMask, expMask);
  endtask

  task automatic finishErase(input logic [7:0] expMask);
    @(negedge clk);
    check(!startOut, "R6 pulse width", startOut, 0);
    strobe(3, 2);
    strobe(6, 1);
    @(negedge clk);
    check(selMask == expMask && busyOut, "R7 mask held", selMask, expMask);
    doneIn = 1'b1;
    @(negedge clk);
    doneIn = 1'b0;
    check(selMask == 8'h00 && !busyOut, "R8 cleared", {busyOut, selMask}, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(selMask == 0 && !startOut && !busyOut, "R1 reset", {startOut, busyOut, selMask}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: idle strobes and abort are ignored
    strobe(5, 2);
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    gap(T + 2, "R10 idle no start");
    check(selMask == 0 && !busyOut, "R10 idle mask", selMask, 0);

    // R2, R5: every single block through arm only
    for (int b = 0; b < 8; b++) begin
      arm(b);
      check(selMask == 8'(1 << b), "R2 arm sets block", selMask, 8'(1 << b));
      expectStart(8'(1 << b), "R5 arm-only");
      finishErase(8'(1 << b));
    end

    // R3: mask patterns built from strobes with gaps inside the window
    for (int p = 0; p < 16; p++) begin
      logic [7:0] pat;
      int first;
      pat = 8'((p * 37 + 11) % 255 + 1);
      first = -1;
      for (int b = 7; b >= 0; b--) if (pat[b]) first = b;
      arm(first);
      for (int b = 0; b < 8; b++) begin
        if (pat[b] && b != first) begin
          gap(T - 2, "R3 window open");
          strobe(b, 1 + (b % 2));
        end
      end
      expectStart(pat, "R3 accumulate");
      finishErase(pat);
    end

    // R4: repeated block restarts window, leaves other bits
    arm(2);
    strobe(4, 1);
    gap(T - 1, "R4 window open");
    strobe(4, 1);
    gap(T - 1, "R4 window re-armed");
    strobe(4, 1);
    check(selMask == 8'h14, "R4 repeat mask", selMask, 8'h14);
    expectStart(8'h14, "R4 repeat");
    finishErase(8'h14);

    // R11: long strobe holds the window
    arm(0);
    strobe(7, 3 * T);
    check(!startOut && !busyOut, "R11 held strobe", busyOut, 0);
    expectStart(8'h81, "R11 after long strobe");
    finishErase(8'h81);

    // R9: abort during loading
    arm(1);
    strobe(5, 1);
    gap(2, "R9 before abort");
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    check(selMask == 0 && !busyOut, "R9 abort clears", selMask, 0);
    gap(T + 3, "R9 no start after abort");
    strobe(6, 1);
    @(negedge clk);
    check(selMask == 0, "R9 back in idle", selMask, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule